// File: doc/BRIEF.md
# Live Value Table for a Multiported Memory

This block is the bookkeeping half of a memory that has several write ports and several read ports, each served every cycle. The data sits in separate banks, one per write port, and each bank holds only what its own port wrote. For every address of the full memory, the block holds the number of the write port that touched that address most recently. When a read port asks for an address, the block returns that number, and the number picks which bank's output reaches the reader.

An entry stores only a port number, so it is ceil(log2 M) bits wide no matter how wide the data is. The table is built from flip-flops and multiplexers. It accepts M writes and N reads in every clock with no stalls. Each read result is registered, so it arrives in the same cycle as the data from the synchronous banks it steers.

Top module: `lvt_table`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every `rd_sel` field reads 0. Every table entry holds 0 after reset, and write enables asserted during reset have no effect.
- R2: A write on port k (bit k of `wr_en`) stores the value k at the address in field k of `wr_addr`. A later read of that address returns k.
- R3: Each read is registered. Field r of `rd_sel` shows the entry for field r of `rd_addr` one clock edge after the address is sampled, and it does not change between edges.
- R4: When several enabled write ports name the same address in one cycle, the entry takes the number of the highest-numbered of them.
- R5: A read and a write to the same address in the same cycle return the entry's value from before that write.
- R6: A write port whose enable bit is 0 changes no entry, whatever its address field holds.
- R7: All N read ports work at once and on their own, including several ports reading one address.
- R8: Writes from different ports to different addresses in the same cycle all take effect, and entries that no write names keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NUM_WR | Write enable; bit k belongs to write port k |
| wr_addr | input | NUM_WR*ADDR_W | Write addresses; port k uses bits [k*ADDR_W +: ADDR_W] |
| rd_addr | input | NUM_RD*ADDR_W | Read addresses; port r uses bits [r*ADDR_W +: ADDR_W] |
| rd_sel | output | NUM_RD*IDX_W | Registered bank number per read port; port r uses bits [r*IDX_W +: IDX_W] |

## Verification
The hardest case to reach is a cycle where several writers and readers meet on one address. There the highest-port rule and the old-value-on-read rule act together, and uniform random addresses over the full depth almost never produce it. Most random cycles therefore draw addresses from a four-entry hot set, so that three-way and four-way write collisions coincide with reads of the same entry. Directed cycles cover the plain collision, the read-during-write case, and disabled ports that point at live entries.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
  // width of a stored write-port number; at least one bit
  function automatic int idx_width(input int num_ports);
    return (num_ports > 1) ? $clog2(num_ports) : 1;
  endfunction
endpackage

// File: rtl/lvt_wr_resolve.sv
// Per-entry write decode: for each address, find whether any enabled
// port names it and which is the highest such port.
module lvt_wr_resolve #(
  parameter int NUM_WR = 4,
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 2,
  parameter int DEPTH  = 32
) (
  input  logic [NUM_WR-1:0]        wr_en,
  input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
  output logic [DEPTH-1:0]         upd_en,
  output logic [DEPTH*IDX_W-1:0]   upd_idx
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic             hit;
    logic [IDX_W-1:0] win;
    always_comb begin
      hit = 1'b0;
      win = '0;
      // ascending scan: a later (higher) port overrides an earlier one
      for (int k = 0; k < NUM_WR; k++) begin
        if (wr_en[k] && (wr_addr[k*ADDR_W +: ADDR_W] == ADDR_W'(e))) begin
          hit = 1'b1;
          win = IDX_W'(k);
        end
      end
    end
    assign upd_en[e]                 = hit;
    assign upd_idx[e*IDX_W +: IDX_W] = win;
  end
endmodule

// File: rtl/lvt_store.sv
// Register array holding one write-port number per address.
module lvt_store #(
  parameter int IDX_W = 2,
  parameter int DEPTH = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DEPTH-1:0]       upd_en,
  input  logic [DEPTH*IDX_W-1:0] upd_idx,
  output logic [DEPTH*IDX_W-1:0] tbl
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_cell
    logic [IDX_W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (rst)            cell_q <= '0;
      else if (upd_en[e]) cell_q <= upd_idx[e*IDX_W +: IDX_W];
    end
    assign tbl[e*IDX_W +: IDX_W] = cell_q;
  end
endmodule

// File: rtl/lvt_rd_port.sv
// One read port: selects an entry and registers it.  The table value
// seen here is the one before this edge's writes.
module lvt_rd_port #(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 2,
  parameter int DEPTH  = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DEPTH*IDX_W-1:0] tbl,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [IDX_W-1:0]       rd_sel
);
  logic [IDX_W-1:0] pick;
  always_comb pick = tbl[rd_addr*IDX_W +: IDX_W];

  always_ff @(posedge clk) begin
    if (rst) rd_sel <= '0;
    else     rd_sel <= pick;
  end
endmodule

// File: rtl/lvt_table.sv
module lvt_table #(
  parameter int NUM_WR = 4,
  parameter int NUM_RD = 3,
  parameter int ADDR_W = 5,
  localparam int IDX_W = lvt_pkg::idx_width(NUM_WR),
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_WR-1:0]        wr_en,
  input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
  input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
  output logic [NUM_RD*IDX_W-1:0]  rd_sel
);
  logic [DEPTH-1:0]       upd_en;
  logic [DEPTH*IDX_W-1:0] upd_idx;
  logic [DEPTH*IDX_W-1:0] tbl_flat;

  lvt_wr_resolve #(
    .NUM_WR(NUM_WR), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH)
  ) u_resolve (
    .wr_en(wr_en), .wr_addr(wr_addr), .upd_en(upd_en), .upd_idx(upd_idx)
  );

  lvt_store #(
    .IDX_W(IDX_W), .DEPTH(DEPTH)
  ) u_store (
    .clk(clk), .rst(rst), .upd_en(upd_en), .upd_idx(upd_idx), .tbl(tbl_flat)
  );

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    lvt_rd_port #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH)
    ) u_rd (
      .clk(clk), .rst(rst), .tbl(tbl_flat),
      .rd_addr(rd_addr[r*ADDR_W +: ADDR_W]),
      .rd_sel(rd_sel[r*IDX_W +: IDX_W])
    );
  end
endmodule

// File: rtl/lvt_table_chk.sv
module lvt_table_chk #(
  parameter int NUM_WR = 4,
  parameter int NUM_RD = 3,
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 2,
  parameter int DEPTH  = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_WR-1:0]        wr_en,
  input logic [NUM_WR*ADDR_W-1:0] wr_addr,
  input logic [NUM_RD*ADDR_W-1:0] rd_addr,
  input logic [NUM_RD*IDX_W-1:0]  rd_sel,
  input logic [DEPTH*IDX_W-1:0]   tbl
);
  // shadow of the table, updated with an explicit priority search
  logic [IDX_W-1:0]        shadow [DEPTH];
  logic [NUM_RD*IDX_W-1:0] exp_q;

  function automatic logic outranked(input int k, input logic [NUM_WR-1:0] en,
                                     input logic [NUM_WR*ADDR_W-1:0] wa);
    for (int j = k + 1; j < NUM_WR; j++)
      if (en[j] && wa[j*ADDR_W +: ADDR_W] == wa[k*ADDR_W +: ADDR_W]) return 1'b1;
    return 1'b0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < DEPTH; e++) shadow[e] <= '0;
      exp_q <= '0;
    end else begin
      for (int r = 0; r < NUM_RD; r++)
        exp_q[r*IDX_W +: IDX_W] <= shadow[rd_addr[r*ADDR_W +: ADDR_W]];
      for (int k = 0; k < NUM_WR; k++)
        if (wr_en[k] && !outranked(k, wr_en, wr_addr))
          shadow[wr_addr[k*ADDR_W +: ADDR_W]] <= IDX_W'(k);
    end
  end

  // R1: reset leaves table and read outputs at zero
  a_r1_reset_clears: assert property (@(posedge clk)
    $fell(rst) |-> (tbl == '0 && rd_sel == '0));

  // R3 / R5 / R7: registered read of the pre-write value on every port
  a_r5_read_old_value: assert property (@(posedge clk) disable iff (rst)
    rd_sel == exp_q);

  // R6: no enable, no change anywhere in the table
  a_r6_idle_keeps_table: assert property (@(posedge clk) disable iff (rst)
    (wr_en == '0) |=> $stable(tbl));

  for (genvar k = 0; k < NUM_WR; k++) begin : g_wr
    logic              won_q;
    logic [ADDR_W-1:0] addr_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        won_q  <= 1'b0;
        addr_q <= '0;
      end else begin
        won_q  <= wr_en[k] && !outranked(k, wr_en, wr_addr);
        addr_q <= wr_addr[k*ADDR_W +: ADDR_W];
      end
    end
    // R2 / R4: the unoutranked writer's number lands in its entry
    a_r4_highest_port_wins: assert property (@(posedge clk) disable iff (rst)
      won_q |-> (tbl[addr_q*IDX_W +: IDX_W] == IDX_W'(k)));
  end
endmodule

bind lvt_table lvt_table_chk #(
  .NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_addr(rd_addr), .rd_sel(rd_sel), .tbl(tbl_flat)
);

// File: tb/lvt_table_tb.sv
module lvt_table_tb;
  localparam int M  = 4;
  localparam int N  = 3;
  localparam int AW = 5;
  localparam int IW = 2;
  localparam int D  = 1 << AW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [M-1:0]      wr_en   = '0;
  logic [M*AW-1:0]   wr_addr = '0;
  logic [N*AW-1:0]   rd_addr = '0;
  logic [N*IW-1:0]   rd_sel;

  int checks = 0;
  int fails  = 0;

  logic [IW-1:0]   model [D];
  logic [N*IW-1:0] exp_sel;
  logic            pend = 1'b0;
  string           pend_tag;

  always #10 clk = ~clk;

  lvt_table #(.NUM_WR(M), .NUM_RD(N), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .rd_sel(rd_sel)
  );

  task automatic check(input string tag, input logic [IW-1:0] act, input logic [IW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected entry after one cycle of writes: highest enabled port wins
  function automatic void apply_writes(input logic [M-1:0] en, input logic [M*AW-1:0] wa);
    for (int k = M - 1; k >= 0; k--) begin
      if (en[k]) begin
        logic taken = 1'b0;
        for (int j = k + 1; j < M; j++)
          if (en[j] && wa[j*AW +: AW] == wa[k*AW +: AW]) taken = 1'b1;
        if (!taken) model[wa[k*AW +: AW]] = IW'(k);
      end
    end
  endfunction

  task automatic step(input logic [M-1:0] en, input logic [M*AW-1:0] wa,
                      input logic [N*AW-1:0] ra, input string tag);
    logic [N*IW-1:0] held;
    @(negedge clk);
    held = rd_sel;
    if (pend)
      for (int r = 0; r < N; r++)
        check(pend_tag, rd_sel[r*IW +: IW], exp_sel[r*IW +: IW]);
    wr_en = en; wr_addr = wa; rd_addr = ra;
    for (int r = 0; r < N; r++) exp_sel[r*IW +: IW] = model[ra[r*AW +: AW]];
    apply_writes(en, wa);
    pend = 1'b1; pend_tag = tag;
    #1;
    // R3: new address must not reach the output before the edge
    check("R3 held between edges", rd_sel[IW-1:0], held[IW-1:0]);
  endtask

  function automatic logic [M*AW-1:0] wpack(input int a0, a1, a2, a3);
    return {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
  endfunction
  function automatic logic [N*AW-1:0] rpack(input int a0, a1, a2);
    return {AW'(a2), AW'(a1), AW'(a0)};
  endfunction
  function automatic int raddr();
    return (($urandom % 4) != 0) ? int'($urandom % 4) : int'($urandom % D);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int e = 0; e < D; e++) model[e] = '0;
    // writes held during reset must be dropped (R1)
    wr_en = '1; wr_addr = wpack(1, 2, 3, 4);
    repeat (3) @(negedge clk);
    check("R1 output during reset", rd_sel[IW-1:0], '0);
    rst = 1'b0; wr_en = '0;
    @(negedge clk);
    for (int r = 0; r < N; r++) check("R1 output after reset", rd_sel[r*IW +: IW], '0);
    step('0, '0, rpack(1, 2, 3), "R1 entries zero after reset");
    step('0, '0, rpack(4, 0, 31), "R1 entries zero after reset");

    // R2: single writers, one per port
    for (int k = 0; k < M; k++)
      step(M'(1 << k), wpack(4 + k, 4 + k, 4 + k, 4 + k), '0, "R2 lone write");
    step('0, '0, rpack(4, 5, 6), "R2 read back port number");
    step('0, '0, rpack(7, 7, 7), "R7 shared address on all readers");

    // R4: collisions
    step(4'b1111, wpack(9, 9, 9, 9), '0, "R4 four-way collision");
    step(4'b0011, wpack(10, 10, 0, 0), rpack(9, 9, 9), "R4 highest port wins");
    step(4'b0101, wpack(11, 0, 11, 0), rpack(10, 9, 0), "R4 highest port wins");
    step('0, '0, rpack(11, 10, 9), "R4 highest port wins");

    // R5: read and write same address in one cycle
    step(4'b0100, wpack(0, 0, 12, 0), rpack(12, 12, 6), "R5 read returns old value");
    step('0, '0, rpack(12, 12, 12), "R5 new value next cycle");

    // R6: disabled ports aimed at live entries
    step(4'b0000, wpack(5, 6, 7, 12), rpack(5, 6, 7), "R6 disabled port no effect");
    step(4'b0000, wpack(5, 6, 7, 12), rpack(12, 4, 9), "R6 disabled port no effect");
    step('0, '0, rpack(5, 6, 7), "R6 disabled port no effect");

    // R8: distinct addresses in one cycle, untouched entries kept
    step(4'b1111, wpack(20, 21, 22, 23), rpack(20, 21, 22), "R8 parallel distinct writes");
    step('0, '0, rpack(20, 21, 23), "R8 parallel distinct writes");
    step('0, '0, rpack(22, 11, 10), "R8 untouched entries kept");

    // random traffic with a hot address set to force collisions (R7)
    for (int i = 0; i < 3000; i++)
      step(M'($urandom), wpack(raddr(), raddr(), raddr(), raddr()),
           rpack(raddr(), raddr(), raddr()), "R7 random mixed traffic");
    step('0, '0, '0, "R7 random mixed traffic");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule